// File: doc/BRIEF.md
# Fractional microsecond timebase

This block derives a steady one-microsecond tick from a reference clock whose frequency need not be a whole number of megahertz. A rational divider, programmed as a dividend/divisor pair, feeds a phase accumulator. Each reference cycle the accumulator adds the dividend. Whenever the sum reaches the divisor, the divisor is taken off and a tick is issued. Over any run of `divisor` cycles exactly `dividend` ticks come out, so a 19.2 MHz reference yields an exact 1 MHz average rate (5 ticks per 96 cycles).

Each tick advances a free-running microsecond counter that wraps to zero. Other timers use the tick pulse directly. Software reads the counter, reads and writes the divider setting (so it can be saved and restored), and can freeze the timebase through a small register port. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter reads 0, the tick is low, freeze reads 0 and the divider setting reads 0x0000000B (divide by 12).
- R2: The divider setting holds the divisor minus one in bits [7:0] and the dividend minus one in bits [15:8]. Counting from the edge after a setting is written, on the n-th unfrozen cycle the tick is high exactly when floor(n*dividend/divisor) exceeds floor((n-1)*dividend/divisor). Examples: 0x000B gives every 12th cycle, 0x000C every 13th, 0x0019 every 26th, and 0x045F gives 5 ticks per 96 cycles.
- R3: `us_tick` is a single-cycle pulse per tick, and `us_count` increases by exactly one on the same edge that raises `us_tick`. It is unchanged otherwise.
- R4: The counter is read at address 0x10, zero-extended. A write to 0x10 changes nothing.
- R5: The divider setting is written at address 0x14 from `bus_wdata[15:0]`. It reads back in bits [15:0], with bits [31:16] reading 0.
- R6: Freeze is bit 0 at address 0x4C, readable back. From the edge after it is set, no tick is issued and the counter holds. On clearing, counting resumes with the accumulator phase it held.
- R7: A write of the divider setting clears the accumulator phase, and no tick is issued on that edge.
- R8: The counter wraps from all ones to zero on a tick.
- R9: Addresses other than 0x10, 0x14 and 0x4C read as 0.
- R10: The setting must keep dividend no greater than divisor. Under that rule the accumulator stays below the divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| us_count | output | CNT_W (32) | Microsecond counter |
| us_tick | output | 1 | One-cycle microsecond tick pulse |

## Verification
A wrong accumulator phase appears at `us_tick` within one divisor period. The tick lands a cycle early or late against the floor-ratio rule, or the tick count over 96 cycles differs from 5. Any dropped or doubled increment leaves `us_count` off by one from the edge of the tick onward, and it stays off, so a per-cycle comparison catches it immediately. A freeze or restart fault shows as a tick on the edge after the control write, and a narrow-counter instance exposes a wrong wrap within a few hundred cycles.

// File: rtl/usec_pkg.sv
package usec_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CFG_W   = 2 * FIELD_W;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FREEZE = 8'h4C;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'h000B;

  typedef logic [FIELD_W:0] acc_t;

  typedef struct packed {
    logic tick;
    acc_t acc;
  } step_t;

  function automatic acc_t cfg_divisor(input logic [CFG_W-1:0] cfg);
    return {1'b0, cfg[FIELD_W-1:0]} + acc_t'(1);
  endfunction

  function automatic acc_t cfg_dividend(input logic [CFG_W-1:0] cfg);
    return {1'b0, cfg[CFG_W-1:FIELD_W]} + acc_t'(1);
  endfunction

  // One accumulator step: add dividend, wrap by divisor, flag a tick.
  function automatic step_t acc_step(input acc_t acc, input acc_t dvd, input acc_t dvs);
    step_t r;
    acc_t  sum;
    sum = acc + dvd;
    if (sum >= dvs) begin
      r.tick = 1'b1;
      r.acc  = sum - dvs;
    end else begin
      r.tick = 1'b0;
      r.acc  = sum;
    end
    return r;
  endfunction
endpackage

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              frz_q,
  output logic              cfg_wr
);
  logic frz_wr;

  assign cfg_wr = bus_wr && (bus_addr == OFS_CFG);
  assign frz_wr = bus_wr && (bus_addr == OFS_FREEZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      frz_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= bus_wdata[CFG_W-1:0];
      if (frz_wr) frz_q <= bus_wdata[0];
    end
  end
endmodule

// File: rtl/usec_frac_div.sv
module usec_frac_div
  import usec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             freeze,
  input  logic             restart,
  output logic             tick_next,
  output logic             tick_q,
  output acc_t             acc_q
);
  step_t nxt;

  always_comb begin
    nxt       = acc_step(acc_q, cfg_dividend(cfg), cfg_divisor(cfg));
    tick_next = nxt.tick && !freeze && !restart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (freeze) begin
      tick_q <= 1'b0;
    end else begin
      acc_q  <= nxt.acc;
      tick_q <= nxt.tick;
    end
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count_q <= '0;
    else if (inc) count_q <= count_q + CNT_W'(1);
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  us_count,
  output logic              us_tick
);
  logic [CFG_W-1:0] cfg_q;
  logic             frz_q;
  logic             cfg_wr;
  logic             tick_next;
  acc_t             acc_q;

  usec_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg_q(cfg_q), .frz_q(frz_q), .cfg_wr(cfg_wr)
  );

  usec_frac_div u_div (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .freeze(frz_q), .restart(cfg_wr),
    .tick_next(tick_next), .tick_q(us_tick), .acc_q(acc_q)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(tick_next), .count_q(us_count)
  );

  always_comb begin
    case (bus_addr)
      OFS_COUNT:  bus_rdata = DATA_W'(us_count);
      OFS_CFG:    bus_rdata = DATA_W'(cfg_q);
      OFS_FREEZE: bus_rdata = DATA_W'(frz_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
  import usec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  us_count,
  input logic              us_tick,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              frz_q,
  input acc_t              acc_q
);
  assert_count_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    us_count == $past(us_count) + CNT_W'(us_tick));

  assert_no_tick_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    us_tick |-> !$past(frz_q));

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CFG) |=> !us_tick);

  assert_cfg_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CFG) |=> cfg_q == $past(bus_wdata[CFG_W-1:0]));

  assert_acc_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dividend(cfg_q) <= cfg_divisor(cfg_q)) |-> (acc_q < cfg_divisor(cfg_q)));
endmodule

bind usec_timebase usec_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .us_count(us_count), .us_tick(us_tick),
  .cfg_q(cfg_q), .frz_q(frz_q), .acc_q(acc_q)
);

// File: tb/usec_timebase_tb.sv
`timescale 1ns/1ps
module usec_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] us_count;
  logic        us_tick;
  logic [31:0] nar_rdata;
  logic [7:0]  nar_count;
  logic        nar_tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] m_cfg = 16'h000B;
  bit          m_frz = 1'b0;
  longint      m_n = 0;
  logic [31:0] m_cnt = '0;
  bit          m_tick = 1'b0;
  string       m_tick_tag = "R1";

  always #2 clk = ~clk;

  usec_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .us_count(us_count), .us_tick(us_tick)
  );

  usec_timebase #(.CNT_W(8)) u_narrow (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(nar_rdata), .us_count(nar_count), .us_tick(nar_tick)
  );

  function automatic longint ticks_upto(longint n, longint dvd, longint dvs);
    return (n * dvd) / dvs;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h10: return m_cnt;
      8'h14: return {16'h0, m_cfg};
      8'h4C: return {31'h0, m_frz};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [7:0] a);
    case (a)
      8'h10: return "R4";
      8'h14: return "R5";
      8'h4C: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model one clock edge with the given bus inputs
  task automatic model_step(bit wr, logic [7:0] a, logic [31:0] d);
    longint dvd, dvs;
    if (wr && a == 8'h14) begin
      m_cfg = d[15:0];
      m_n = 0;
      m_tick = 1'b0;
      m_tick_tag = "R7";
    end else if (m_frz) begin
      m_tick = 1'b0;
      m_tick_tag = "R6";
    end else begin
      dvd = longint'(m_cfg[15:8]) + 1;
      dvs = longint'(m_cfg[7:0]) + 1;
      m_n++;
      m_tick = ticks_upto(m_n, dvd, dvs) != ticks_upto(m_n - 1, dvd, dvs);
      if (m_tick) m_cnt = m_cnt + 32'd1;
      m_tick_tag = "R2";
    end
    if (wr && a == 8'h4C) m_frz = d[0];
  endtask

  // drive at negedge, step one edge, compare at the following negedge
  task automatic cycle(bit wr, logic [7:0] a, logic [31:0] d);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    model_step(wr, a, d);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check(m_tick_tag, {31'h0, us_tick}, {31'h0, m_tick});
    check("R3", us_count, m_cnt);
    check("R8", {24'h0, nar_count}, {24'h0, m_cnt[7:0]});
    check(read_tag(a), bus_rdata, model_read(a));
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 5)
      0: return 8'h10;
      1: return 8'h14;
      2: return 8'h4C;
      3: return 8'h14;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] legal_cfg();
    logic [7:0] dv, dd;
    dv = 8'($urandom);
    dd = 8'($urandom % (int'(dv) + 1));
    return {16'($urandom), dd, dv};
  endfunction

  task automatic run_idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, pick_addr(), 32'h0);
  endtask

  initial begin
    int seed;
    int pct;
    seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", us_count, 32'h0);
      check("R1", {31'h0, us_tick}, 32'h0);
    end
    rst_n = 1'b1;
    cycle(1'b0, 8'h14, 32'h0);
    check("R1", bus_rdata, 32'h0000000B);
    cycle(1'b0, 8'h4C, 32'h0);
    check("R1", bus_rdata, 32'h0);
    // R2: default divide-by-12 pattern
    run_idle(40);
    // R2: directed settings from common references
    cycle(1'b1, 8'h14, 32'h0000000C); run_idle(60);
    cycle(1'b1, 8'h14, 32'h00000019); run_idle(60);
    cycle(1'b1, 8'h14, 32'hABCD045F); run_idle(200);
    // R6: freeze mid-phase, hold, resume
    cycle(1'b1, 8'h4C, 32'h1); run_idle(30);
    cycle(1'b0, 8'h4C, 32'h0);
    check("R6", bus_rdata, 32'h1);
    cycle(1'b1, 8'h4C, 32'h0); run_idle(100);
    // R4: counter write ignored
    cycle(1'b1, 8'h10, 32'hDEADBEEF);
    cycle(1'b0, 8'h10, 32'h0);
    // R8: tick every cycle to drive the narrow counter through wrap
    cycle(1'b1, 8'h14, 32'h00000000); run_idle(300);
    // R9: unmapped reads
    cycle(1'b0, 8'h00, 32'h0);
    cycle(1'b0, 8'hFC, 32'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      pct = $urandom % 100;
      if (pct < 2)      cycle(1'b1, 8'h14, legal_cfg());
      else if (pct < 4) cycle(1'b1, 8'h4C, {31'($urandom), 1'($urandom % 3 == 0)});
      else if (pct < 6) cycle(1'b1, 8'h10, $urandom);
      else              cycle(1'b0, pick_addr(), 32'h0);
    end
    cycle(1'b1, 8'h4C, 32'h0);
    cycle(1'b1, 8'h14, 32'h0000045F); run_idle(192);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule